// File: doc/BRIEF.md
# Atomic Swap and Compare-Swap Memory Port

This block sits in front of a small byte-addressable storage array and serves one request at a time. It handles five commands: plain read, plain write, unconditional swap, compare-and-swap, and invalidate. A request carries an address, a size of 1, 2, 4 or 8 bytes, store data, a compare value, an inhibit flag and a response-wanted flag. Byte lanes are little-endian, so lane 0 of the data bus maps to the lowest address.

A swap reads the old contents, which go back in the response, and stores the request's data. The compare variant stores only when the old contents equal the compare value. Compare-and-swap is legal only at 4 and 8 bytes, and a 4-byte compare looks only at the low 32 bits of the compare value. A swap is accepted in one cycle and writes in the next. During that second cycle the port holds its ready low, so no other request can slip between the read and the write.

Plain writes obey an external write-allowed input that comes from reservation logic outside the block. An inhibited request touches nothing and produces no response. Every response appears a fixed, parameterised number of cycles after the request is accepted.

Top module: `amo_mem_port`

## Requirements
- R1: After reset and before any request, rsp_valid is 0 and req_ready is 1.
- R2: A read (req_cmd 0) accepted in cycle c with req_need_rsp=1 gives rsp_valid=1 in cycle c+LATENCY and 0 in cycles c+1 to c+LATENCY-1. rsp_data lane k (bits 8k+7:8k) holds the byte at address+k for k below the size (req_size 0,1,2,3 = 1,2,4,8 bytes), higher lanes are zero, and rsp_err=0.
- R3: A write (req_cmd 1) stores its low size bytes little-endian when wr_allowed=1. When wr_allowed=0 memory stays unchanged and no error is flagged. Its response carries rsp_data=0.
- R4: A swap (req_cmd 2) returns the old contents in the response and stores req_wdata at the given size.
- R5: A compare-and-swap (req_cmd 3) at size 4 or 8 returns the old contents. It stores req_wdata only when the old contents equal req_cmp, with size 4 comparing only req_cmp[31:0].
- R6: A compare-and-swap at size 1 or 2, or a request with req_cmd 5, 6 or 7, responds with rsp_err=1 and rsp_data=0 and leaves memory unchanged.
- R7: A data command whose bytes do not all lie within BASE_ADDR to BASE_ADDR+MEM_BYTES-1 responds with rsp_err=1 and rsp_data=0 and leaves memory unchanged.
- R8: In the cycle after a legal swap or compare-and-swap is accepted, req_ready is 0. It returns to 1 in the following cycle.
- R9: A request with req_inhibit=1 changes no memory and produces no response.
- R10: A response is produced only when req_need_rsp=1. An invalidate (req_cmd 4) touches no data and responds with rsp_data=0 and rsp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request this cycle |
| req_cmd | input | 3 | 0 read, 1 write, 2 swap, 3 compare-swap, 4 invalidate |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Log2 of the byte count |
| req_wdata | input | 64 | Store / swap data, little-endian lanes |
| req_cmp | input | 64 | Compare value for compare-swap |
| req_inhibit | input | 1 | Suppress the whole access |
| req_need_rsp | input | 1 | A response is wanted |
| wr_allowed | input | 1 | External permission for plain writes |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | 64 | Old or read data, zero otherwise |
| rsp_err | output | 1 | Range or legality error |

## Verification
A request accepted at one rising edge has its response due exactly LATENCY cycles later. The bench samples on falling edges and confirms that rsp_valid is low on every earlier falling edge and that the response payload is correct on the due one. For a swap, the ready drop is due on the first falling edge after acceptance. The swap's store is confirmed by a later read. Effects on memory (blocked writes, errors, inhibits, failed compares) are checked through follow-up reads against a bench byte model, and each request waits for its own response before the next is driven.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_SWAP  = 3'd2,
    CMD_CSWAP = 3'd3,
    CMD_INVAL = 3'd4
  } amo_cmd_e;

  typedef struct packed {
    logic              err;
    logic [DATA_W-1:0] data;
  } amo_rsp_t;
endpackage

// File: rtl/amo_req_decode.sv
module amo_req_decode
  import amo_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 256,
  parameter int MEM_BYTES = 256,
  localparam int OFF_W    = $clog2(MEM_BYTES)
) (
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [OFF_W-1:0]  off,
  output logic [3:0]        nbytes,
  output logic              is_rd,
  output logic              is_wr,
  output logic              is_swap,
  output logic              is_cswap,
  output logic              bad
);
  localparam logic [ADDR_W:0] LO_LIM = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI_LIM = (ADDR_W+1)'(BASE_ADDR + MEM_BYTES);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] end_x;
  logic [ADDR_W:0] rel_x;
  logic            in_range;
  logic            is_data;
  logic            is_inval;
  logic            size_bad;

  always_comb begin
    nbytes   = 4'd1 << size;
    addr_x   = {1'b0, addr};
    end_x    = addr_x + {{(ADDR_W-3){1'b0}}, nbytes};
    rel_x    = addr_x - LO_LIM;
    off      = rel_x[OFF_W-1:0];
    in_range = (addr_x >= LO_LIM) && (end_x <= HI_LIM);
    is_rd    = (cmd == CMD_READ);
    is_wr    = (cmd == CMD_WRITE);
    is_swap  = (cmd == CMD_SWAP);
    is_cswap = (cmd == CMD_CSWAP);
    is_inval = (cmd == CMD_INVAL);
    is_data  = is_rd | is_wr | is_swap | is_cswap;
    size_bad = is_cswap && (size < 2'd2);
    bad      = !(is_data || is_inval) || size_bad || (is_data && !in_range);
  end
endmodule

// File: rtl/amo_byte_ram.sv
module amo_byte_ram
  import amo_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int OFF_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [3:0]        rd_nbytes,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [3:0]        wr_nbytes,
  input  logic [DATA_W-1:0] wr_data
);
  logic [7:0] mem [MEM_BYTES];

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if ((k < int'(rd_nbytes)) && (int'(rd_off) + k < MEM_BYTES))
        rd_data[8*k +: 8] = mem[OFF_W'(int'(rd_off) + k)];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) begin
        if ((k < int'(wr_nbytes)) && (int'(wr_off) + k < MEM_BYTES))
          mem[OFF_W'(int'(wr_off) + k)] <= wr_data[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/amo_rsp_pipe.sv
module amo_rsp_pipe
  import amo_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  amo_rsp_t in_rsp,
  output logic     out_valid,
  output amo_rsp_t out_rsp
);
  logic     stg_v [LATENCY];
  amo_rsp_t stg_p [LATENCY];

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    logic     v_in;
    amo_rsp_t p_in;
    if (s == 0) begin : g_head
      assign v_in = in_valid;
      assign p_in = in_rsp;
    end else begin : g_body
      assign v_in = stg_v[s-1];
      assign p_in = stg_p[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_v[s] <= 1'b0;
      else        stg_v[s] <= v_in;
    end

    always_ff @(posedge clk) begin
      if (v_in) stg_p[s] <= p_in;
    end
  end

  assign out_valid = stg_v[LATENCY-1];
  assign out_rsp   = stg_p[LATENCY-1];
endmodule

// File: rtl/amo_mem_port.sv
module amo_mem_port
  import amo_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 256,
  parameter int MEM_BYTES = 256,
  parameter int LATENCY   = 3,
  localparam int OFF_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_cmp,
  input  logic              req_inhibit,
  input  logic              req_need_rsp,
  input  logic              wr_allowed,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_err
);
  typedef enum logic {ST_IDLE, ST_SWAP_WR} st_e;

  st_e               st_q, st_d;
  logic [OFF_W-1:0]  dec_off;
  logic [3:0]        dec_nbytes;
  logic              dec_rd, dec_wr, dec_swap, dec_cswap, dec_err;
  logic [DATA_W-1:0] old_data;
  logic              acc, cmp_hit, start_swap;
  logic [OFF_W-1:0]  sw_off_q;
  logic [3:0]        sw_nb_q;
  logic [DATA_W-1:0] sw_wd_q;
  logic              sw_do_q;
  logic              ram_we;
  logic [OFF_W-1:0]  ram_woff;
  logic [3:0]        ram_wnb;
  logic [DATA_W-1:0] ram_wd;
  amo_rsp_t          pipe_in, pipe_out;
  logic              pipe_in_v;

  amo_req_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MEM_BYTES(MEM_BYTES)) u_dec (
    .cmd(req_cmd), .addr(req_addr), .size(req_size), .off(dec_off), .nbytes(dec_nbytes),
    .is_rd(dec_rd), .is_wr(dec_wr), .is_swap(dec_swap), .is_cswap(dec_cswap), .bad(dec_err)
  );

  amo_byte_ram #(.MEM_BYTES(MEM_BYTES)) u_ram (
    .clk(clk), .rd_off(dec_off), .rd_nbytes(dec_nbytes), .rd_data(old_data),
    .wr_en(ram_we), .wr_off(ram_woff), .wr_nbytes(ram_wnb), .wr_data(ram_wd)
  );

  always_comb begin
    req_ready  = (st_q == ST_IDLE);
    acc        = req_valid && req_ready && !req_inhibit;
    if (dec_nbytes == 4'd4) cmp_hit = (old_data[31:0] == req_cmp[31:0]);
    else                    cmp_hit = (old_data == req_cmp);
    start_swap = acc && !dec_err && (dec_swap || dec_cswap);
    st_d       = st_q;
    case (st_q)
      ST_IDLE:    if (start_swap) st_d = ST_SWAP_WR;
      ST_SWAP_WR: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (start_swap) begin
      sw_off_q <= dec_off;
      sw_nb_q  <= dec_nbytes;
      sw_wd_q  <= req_wdata;
      sw_do_q  <= dec_swap || cmp_hit;
    end
  end

  always_comb begin
    if (st_q == ST_SWAP_WR) begin
      ram_we   = sw_do_q;
      ram_woff = sw_off_q;
      ram_wnb  = sw_nb_q;
      ram_wd   = sw_wd_q;
    end else begin
      ram_we   = acc && !dec_err && dec_wr && wr_allowed;
      ram_woff = dec_off;
      ram_wnb  = dec_nbytes;
      ram_wd   = req_wdata;
    end
  end

  always_comb begin
    pipe_in_v    = acc && req_need_rsp;
    pipe_in.err  = dec_err;
    pipe_in.data = (!dec_err && (dec_rd || dec_swap || dec_cswap)) ? old_data : '0;
  end

  amo_rsp_pipe #(.LATENCY(LATENCY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(pipe_in_v), .in_rsp(pipe_in),
    .out_valid(rsp_valid), .out_rsp(pipe_out)
  );

  assign rsp_data = pipe_out.data;
  assign rsp_err  = pipe_out.err;
endmodule

// File: rtl/amo_mem_port_chk.sv
module amo_mem_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_cmd,
  input logic        req_inhibit,
  input logic        wr_allowed,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_data,
  input logic        acc_err,
  input logic        ram_we
);
  logic take;
  assign take = req_valid && req_ready;

  p_swap_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_inhibit && !acc_err && (req_cmd == 3'd2 || req_cmd == 3'd3) |=> !req_ready);

  p_stall_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  p_inhibit_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_inhibit |-> !ram_we);

  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_inhibit && acc_err |-> !ram_we);

  p_blocked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_cmd == 3'd1 && !wr_allowed |-> !ram_we);

  p_err_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == 64'd0);
endmodule

bind amo_mem_port amo_mem_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .req_inhibit(req_inhibit), .wr_allowed(wr_allowed),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .acc_err(dec_err), .ram_we(ram_we)
);

// File: tb/amo_mem_port_bench.sv
module amo_mem_port_bench;
  localparam int ADDR_W = 16;
  localparam int BASE   = 256;
  localparam int MEMB   = 256;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_inhibit, req_need_rsp, wr_allowed;
  logic [2:0] req_cmd;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0] req_size;
  logic [63:0] req_wdata, req_cmp, rsp_data;
  logic rsp_valid, rsp_err;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [MEMB];

  always #10 clk = ~clk;

  amo_mem_port #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .MEM_BYTES(MEMB), .LATENCY(LAT)) u_amo_mem_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .req_inhibit(req_inhibit), .req_need_rsp(req_need_rsp), .wr_allowed(wr_allowed),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(input int a, input int nb);
    logic [63:0] v = '0;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = model[a - BASE + k];
    return v;
  endfunction

  // bench model of one request; returns expected response and updates model
  task automatic model_req(input logic [2:0] cmd, input int a, input logic [1:0] sz,
                           input logic [63:0] wd, input logic [63:0] cp, input bit inh,
                           input bit wa, output bit err, output logic [63:0] data,
                           output bit is_swap);
    int nb = 1 << sz;
    bit in_rng = (a >= BASE) && (a + nb <= BASE + MEMB);
    bit is_data = (cmd <= 3'd3);
    logic [63:0] old;
    bit hit;
    err = 0; data = '0; is_swap = 0;
    if (cmd > 3'd4) err = 1;
    else if (cmd == 3'd3 && sz < 2'd2) err = 1;
    else if (is_data && !in_rng) err = 1;
    if (inh || err) return;
    if (!is_data) return;
    old = mread(a, nb);
    hit = (nb == 4) ? (old[31:0] == cp[31:0]) : (old == cp);
    case (cmd)
      3'd0: data = old;
      3'd1: if (wa) for (int k = 0; k < nb; k++) model[a - BASE + k] = wd[8*k +: 8];
      default: begin
        data = old; is_swap = 1;
        if (cmd == 3'd2 || hit) for (int k = 0; k < nb; k++) model[a - BASE + k] = wd[8*k +: 8];
      end
    endcase
  endtask

  task automatic run(input string tag, input logic [2:0] cmd, input int a, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [63:0] cp, input bit inh,
                     input bit need, input bit wa);
    bit e_err, e_sw;
    logic [63:0] e_data;
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = ADDR_W'(a); req_size = sz; req_wdata = wd;
    req_cmp = cp; req_inhibit = inh; req_need_rsp = need; wr_allowed = wa;
    model_req(cmd, a, sz, wd, cp, inh, wa, e_err, e_data, e_sw);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (e_sw) chk(req_ready == 1'b0, "R8 ready low during swap", 64'(req_ready), 64'd0);
    for (int k = 1; k < LAT; k++) begin
      chk(rsp_valid == 1'b0, {tag, " R2 early rsp"}, 64'(rsp_valid), 64'd0);
      @(negedge clk);
    end
    if (need && !inh) begin
      chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_err == e_err, {tag, " rsp_err"}, 64'(rsp_err), 64'(e_err));
      chk(rsp_data == e_data, {tag, " rsp_data"}, rsp_data, e_data);
    end else begin
      chk(rsp_valid == 1'b0, {tag, " no response"}, 64'(rsp_valid), 64'd0);
    end
    if (e_sw) chk(req_ready == 1'b1, "R8 ready back", 64'(req_ready), 64'd1);
  endtask

  task automatic rd8(input string tag, input int a);
    run(tag, 3'd0, a, 2'd3, '0, '0, 0, 1, 1);
  endtask

  initial begin
    req_valid = 0; req_cmd = '0; req_addr = '0; req_size = '0; req_wdata = '0; req_cmp = '0;
    req_inhibit = 0; req_need_rsp = 0; wr_allowed = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 idle rsp_valid", 64'(rsp_valid), 64'd0);

    for (int i = 0; i < MEMB / 8; i++)
      run("R3 init write", 3'd1, BASE + 8*i, 2'd3, {$urandom(7 + i), $urandom()}, '0, 0, 1, 1);

    rd8("R2 read 8", BASE + 8);
    run("R2 read 2 unaligned", 3'd0, BASE + 13, 2'd1, '0, '0, 0, 1, 1);
    run("R3 write 2", 3'd1, BASE + 20, 2'd1, 64'hFFFF_FFFF_FFFF_A55A, '0, 0, 1, 1);
    rd8("R3 readback", BASE + 16);
    run("R3 blocked write", 3'd1, BASE + 16, 2'd3, 64'h1111_2222_3333_4444, '0, 0, 1, 0);
    rd8("R3 blocked readback", BASE + 16);
    run("R4 swap 8", 3'd2, BASE + 32, 2'd3, 64'hDEAD_BEEF_0BAD_F00D, '0, 0, 1, 1);
    rd8("R4 swap readback", BASE + 32);
    run("R5 cswap 4 hit upper ignored", 3'd3, BASE + 32, 2'd2, 64'h0000_0000_1234_5678,
        64'hAAAA_AAAA_0BAD_F00D, 0, 1, 1);
    rd8("R5 hit readback", BASE + 32);
    run("R5 cswap 8 miss", 3'd3, BASE + 32, 2'd3, 64'h0, 64'h1, 0, 1, 1);
    rd8("R5 miss readback", BASE + 32);
    run("R6 cswap size1", 3'd3, BASE + 40, 2'd0, 64'hFF, mread(BASE + 40, 1), 0, 1, 1);
    run("R6 cswap size2", 3'd3, BASE + 40, 2'd1, 64'hFFFF, mread(BASE + 40, 2), 0, 1, 1);
    run("R6 bad cmd", 3'd6, BASE + 40, 2'd3, 64'h5, '0, 0, 1, 1);
    rd8("R6 readback", BASE + 40);
    run("R7 top edge ok", 3'd0, BASE + MEMB - 8, 2'd3, '0, '0, 0, 1, 1);
    run("R7 top overrun", 3'd2, BASE + MEMB - 4, 2'd3, 64'h77, '0, 0, 1, 1);
    run("R7 below base", 3'd1, BASE - 1, 2'd1, 64'h77, '0, 0, 1, 1);
    rd8("R7 readback", BASE + MEMB - 8);
    run("R9 inhibit write", 3'd1, BASE + 48, 2'd3, 64'h9999_9999_9999_9999, '0, 1, 1, 1);
    run("R9 inhibit swap", 3'd2, BASE + 48, 2'd3, 64'h8888, '0, 1, 1, 1);
    rd8("R9 readback", BASE + 48);
    run("R10 invalidate", 3'd4, 0, 2'd0, 64'h1234, '0, 0, 1, 1);
    run("R10 no rsp read", 3'd0, BASE, 2'd3, '0, '0, 0, 0, 1);
    run("R10 no rsp swap", 3'd2, BASE + 56, 2'd3, 64'h4242, '0, 0, 0, 1);
    rd8("R10 silent swap readback", BASE + 56);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] c = 3'($urandom_range(0, 5));
      logic [1:0] s = 2'($urandom_range(0, 3));
      int a = BASE - 8 + int'($urandom_range(0, MEMB + 15));
      logic [63:0] cp = {$urandom(), $urandom()};
      int nb = 1 << s;
      string tg;
      if (($urandom_range(0, 1) == 1) && a >= BASE && a + nb <= BASE + MEMB) cp = mread(a, nb);
      case (c)
        3'd0: tg = "R2 rand read";
        3'd1: tg = "R3 rand write";
        3'd2: tg = "R4 rand swap";
        3'd3: tg = "R5 rand cswap";
        3'd4: tg = "R10 rand inval";
        default: tg = "R6 rand bad cmd";
      endcase
      run(tg, c, a, s, {$urandom(), $urandom()}, cp, $urandom_range(0, 7) == 0,
          $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < MEMB / 8; i++) rd8("R3 final sweep", BASE + 8*i);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule